// File: doc/BRIEF.md
# Conversion Status and Interrupt Controller

This block keeps the status picture of a four-channel sensor converter. The conversion engine sends one pulse per finished conversion on each channel. Fault detectors send error pulses, each tagged with a channel number. The block turns these events into three things: sticky status bits, per-channel flags that mark a conversion result nobody has fetched yet, and an active-low interrupt pin. Configuration inputs decide three matters: whether data-ready follows every conversion or only the end of a round-robin scan, how long that scan is, and which sources may pull the interrupt pin.

The register bus decodes accesses and passes them in as one-cycle strobes: one for a read of the status register and one per channel for reads of the data registers. A read of the status register acknowledges everything pending. Sleep entry, shutdown and software reset wipe all state and release the pin. The asynchronous reset input acts as power-on reset.

Top module: `cnv_stat_top`

## Requirements
- R1: With `cfgAutoscan` low, a pulse on any bit of `convDone` sets `statDrdy` on the next clock edge, provided `cfgDrdyEn` is high.
- R2: With `cfgAutoscan` high, only a conversion on the last channel of the scan sets `statDrdy`. The last channel is 1 for `cfgSeqLen` 0, 2 for `cfgSeqLen` 1, and 3 for `cfgSeqLen` 2 or 3. Conversions on other channels leave `statDrdy` unchanged. `statDrdy` never sets while `cfgDrdyEn` is low.
- R3: Bit k of `errEvt` sets bit k of `statErr`, whatever the mask. The bit order is 0 under-range, 1 over-range, 2 watchdog timeout, 3 amplitude high, 4 amplitude low, 5 zero count. `statErrChan` takes `errChan` from the first error event after a clear and keeps it while any error bit stays set.
- R4: `unread[c]` sets one edge after `convDone[c]`. It clears one edge after `rdData[c]` or `rdStatus`.
- R5: `rdStatus` clears `statErr`, `statErrChan`, `statDrdy` and `unread` on the next edge. An event that arrives in the same cycle as the read is recorded anyway: a set wins over the read clear.
- R6: `intN` is low exactly when `cfgIntDis` is low and at least one pending source is enabled. A pending source is an error bit whose `cfgErrMask` bit is set, or `statDrdy` with `cfgDrdyEn` set. `intN` changes on the same edge as the status bits it reflects. With `cfgIntDis` high, `intN` is high.
- R7: A pulse on `sleepEnter` or `swReset`, or any cycle in which `shutdown` is high, clears every status bit, `statErrChan` and every unread flag, and drives `intN` high on the next edge. This clear wins over events that arrive in the same cycle.
- R8: While `rstN` is low, every status output is 0 and `intN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| convDone | input | 4 | Per-channel conversion-finished pulses |
| errEvt | input | 6 | Error event pulses, one bit per error kind |
| errChan | input | 2 | Channel that the error events belong to |
| cfgAutoscan | input | 1 | 1: scan mode, 0: single-channel continuous mode |
| cfgSeqLen | input | 2 | Scan length code (0: ch0-1, 1: ch0-2, 2/3: ch0-3) |
| cfgErrMask | input | 6 | Per-error enable toward the interrupt pin |
| cfgDrdyEn | input | 1 | Data-ready enable for the status bit and the pin |
| cfgIntDis | input | 1 | 1 holds the interrupt pin high |
| rdStatus | input | 1 | Status register read strobe |
| rdData | input | 4 | Per-channel data register read strobes |
| sleepEnter | input | 1 | Sleep entry pulse |
| shutdown | input | 1 | Shutdown level |
| swReset | input | 1 | Software reset pulse |
| statErr | output | 6 | Sticky error bits |
| statErrChan | output | 2 | Channel of the first error since the last clear |
| statDrdy | output | 1 | Sticky data-ready bit |
| unread | output | 4 | Per-channel unread-conversion flags |
| intN | output | 1 | Active-low interrupt pin |

## Verification
Two situations are the hardest to reach from the ports. The first is a status read that lands in the same cycle as a new error or conversion. The second is a second error that arrives while an earlier error is still pending with a different channel tag. Random stimulus alone seldom lines these up, so directed steps arrange each one on purpose. A pulse-level reference model then follows a long random run, in which mode, scan length, masks and the clear sources change mid-stream. That run also covers scan conversions that are not the last in the sequence and must leave data-ready alone.

// File: rtl/cnv_stat_pkg.sv
package cnv_stat_pkg;
  localparam int CH_NUM  = 4;
  localparam int ERR_NUM = 6;
  localparam int CH_W    = $clog2(CH_NUM);

  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic               clrAll;    // sleep / shutdown / software reset
    logic               clrRead;   // status register read
    logic               drdySet;   // data-ready event in the current mode
    logic               chanLoad;  // capture error channel
    logic [CH_NUM-1:0]  unrdSet;
    logic [CH_NUM-1:0]  unrdClr;
  } strb_t;
endpackage

// File: rtl/cnv_stat_ctl.sv
module cnv_stat_ctl
  import cnv_stat_pkg::*;
(
  input  logic [CH_NUM-1:0]  convDone,
  input  logic [ERR_NUM-1:0] errEvt,
  input  logic               cfgAutoscan,
  input  logic [1:0]         cfgSeqLen,
  input  logic               cfgDrdyEn,
  input  logic               rdStatus,
  input  logic [CH_NUM-1:0]  rdData,
  input  logic               sleepEnter,
  input  logic               shutdown,
  input  logic               swReset,
  input  logic               errEmpty,
  output strb_t              strb
);
  logic [CH_W-1:0] lastCh;
  logic            drdyEvt;

  // scan of length code n ends on channel n+1, capped at the top channel
  always_comb begin
    if (cfgSeqLen >= 2'd2) lastCh = CH_W'(CH_NUM - 1);
    else                   lastCh = CH_W'(cfgSeqLen) + CH_W'(1);
  end

  assign drdyEvt = cfgAutoscan ? convDone[lastCh] : (|convDone);

  always_comb begin
    strb.clrAll   = sleepEnter | shutdown | swReset;
    strb.clrRead  = rdStatus;
    strb.drdySet  = drdyEvt & cfgDrdyEn;
    strb.chanLoad = (|errEvt) & (errEmpty | rdStatus);
    strb.unrdSet  = convDone;
    strb.unrdClr  = rdData | {CH_NUM{rdStatus}};
  end
endmodule

// File: rtl/cnv_stat_dp.sv
module cnv_stat_dp
  import cnv_stat_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strb_t              strb,
  input  logic [ERR_NUM-1:0] errEvt,
  input  logic [CH_W-1:0]    errChan,
  input  logic [ERR_NUM-1:0] cfgErrMask,
  input  logic               cfgDrdyEn,
  input  logic               cfgIntDis,
  output logic [ERR_NUM-1:0] statErr,
  output logic [CH_W-1:0]    statErrChan,
  output logic               statDrdy,
  output logic [CH_NUM-1:0]  unread,
  output logic               intN,
  output logic               errEmpty
);
  logic [ERR_NUM-1:0] errNext;
  logic [CH_W-1:0]    chanNext;
  logic               drdyNext;
  logic [CH_NUM-1:0]  unrdNext;
  logic               pendAny;

  assign errEmpty = (statErr == '0);

  always_comb begin
    if (strb.clrAll) begin
      errNext  = '0;
      chanNext = '0;
      drdyNext = 1'b0;
    end else begin
      errNext  = (strb.clrRead ? '0 : statErr) | errEvt;
      chanNext = strb.chanLoad ? errChan : (strb.clrRead ? '0 : statErrChan);
      drdyNext = (statDrdy & ~strb.clrRead) | strb.drdySet;
    end
  end

  for (genvar c = 0; c < CH_NUM; c++) begin : g_unrd
    always_comb begin
      if (strb.clrAll)           unrdNext[c] = 1'b0;
      else if (strb.unrdSet[c])  unrdNext[c] = 1'b1;
      else if (strb.unrdClr[c])  unrdNext[c] = 1'b0;
      else                       unrdNext[c] = unread[c];
    end
  end

  assign pendAny = (|(errNext & cfgErrMask)) | (drdyNext & cfgDrdyEn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statErr     <= '0;
      statErrChan <= '0;
      statDrdy    <= 1'b0;
      unread      <= '0;
      intN        <= 1'b1;
    end else begin
      statErr     <= errNext;
      statErrChan <= chanNext;
      statDrdy    <= drdyNext;
      unread      <= unrdNext;
      intN        <= ~(pendAny & ~cfgIntDis & ~strb.clrAll);
    end
  end
endmodule

// File: rtl/cnv_stat_top.sv
module cnv_stat_top
  import cnv_stat_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [CH_NUM-1:0]  convDone,
  input  logic [ERR_NUM-1:0] errEvt,
  input  logic [CH_W-1:0]    errChan,
  input  logic               cfgAutoscan,
  input  logic [1:0]         cfgSeqLen,
  input  logic [ERR_NUM-1:0] cfgErrMask,
  input  logic               cfgDrdyEn,
  input  logic               cfgIntDis,
  input  logic               rdStatus,
  input  logic [CH_NUM-1:0]  rdData,
  input  logic               sleepEnter,
  input  logic               shutdown,
  input  logic               swReset,
  output logic [ERR_NUM-1:0] statErr,
  output logic [CH_W-1:0]    statErrChan,
  output logic               statDrdy,
  output logic [CH_NUM-1:0]  unread,
  output logic               intN
);
  strb_t strb;
  logic  errEmpty;

  cnv_stat_ctl u_ctl (
    .convDone, .errEvt, .cfgAutoscan, .cfgSeqLen, .cfgDrdyEn,
    .rdStatus, .rdData, .sleepEnter, .shutdown, .swReset,
    .errEmpty, .strb
  );

  cnv_stat_dp u_dp (
    .clk, .rstN, .strb, .errEvt, .errChan, .cfgErrMask, .cfgDrdyEn,
    .cfgIntDis, .statErr, .statErrChan, .statDrdy, .unread, .intN,
    .errEmpty
  );
endmodule

// File: rtl/cnv_stat_chk.sv
module cnv_stat_chk
  import cnv_stat_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [CH_NUM-1:0]  convDone,
  input logic [ERR_NUM-1:0] errEvt,
  input logic               cfgIntDis,
  input logic               rdStatus,
  input logic               sleepEnter,
  input logic               shutdown,
  input logic               swReset,
  input logic [ERR_NUM-1:0] statErr,
  input logic [CH_W-1:0]    statErrChan,
  input logic [CH_NUM-1:0]  unread,
  input logic               intN
);
  logic anyClr;
  assign anyClr = sleepEnter | shutdown | swReset;

  // R6
  int_dis_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgIntDis |=> intN);

  // R7
  clear_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyClr |=> (statErr == '0 && unread == '0 && intN));

  // R5
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStatus && errEvt == '0 && !anyClr) |=> (statErr == '0 && statErrChan == '0));

  // R3
  err_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errEvt != '0 && !anyClr) |=> (statErr != '0));

  // R3
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statErr != '0 && !rdStatus && !anyClr) |=> $stable(statErrChan));

  // R4
  unread_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (convDone != '0 && !anyClr) |=> ((unread & $past(convDone)) == $past(convDone)));
endmodule

bind cnv_stat_top cnv_stat_chk u_chk (
  .clk, .rstN, .convDone, .errEvt, .cfgIntDis, .rdStatus, .sleepEnter,
  .shutdown, .swReset, .statErr, .statErrChan, .unread, .intN
);

// File: tb/tb_cnv_stat_top.sv
module tb_cnv_stat_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] convDone = '0;
  logic [5:0] errEvt = '0;
  logic [1:0] errChan = '0;
  logic       cfgAutoscan = 1'b0;
  logic [1:0] cfgSeqLen = '0;
  logic [5:0] cfgErrMask = '0;
  logic       cfgDrdyEn = 1'b0;
  logic       cfgIntDis = 1'b0;
  logic       rdStatus = 1'b0;
  logic [3:0] rdData = '0;
  logic       sleepEnter = 1'b0;
  logic       shutdown = 1'b0;
  logic       swReset = 1'b0;
  logic [5:0] statErr;
  logic [1:0] statErrChan;
  logic       statDrdy;
  logic [3:0] unread;
  logic       intN;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [5:0] mErr = '0;
  logic [1:0] mChan = '0;
  logic       mDrdy = 1'b0;
  logic [3:0] mUnrd = '0;
  logic       mIntN = 1'b1;

  always #2 clk = ~clk;

  cnv_stat_top dut (.*);

  function automatic int lastOf(input logic [1:0] len);
    return (len == 2'd0) ? 1 : (len == 2'd1) ? 2 : 3;
  endfunction

  function automatic logic drdyEvent(input logic scan, input logic [1:0] len,
                                     input logic [3:0] done4);
    return scan ? done4[lastOf(len)] : (done4 != 4'd0);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    logic [5:0] baseErr;
    if (sleepEnter || shutdown || swReset) begin
      mErr = '0; mChan = '0; mDrdy = 1'b0; mUnrd = '0; mIntN = 1'b1;
    end else begin
      baseErr = rdStatus ? 6'd0 : mErr;
      if (errEvt != 0 && baseErr == 0) mChan = errChan;
      else if (rdStatus)               mChan = '0;
      mErr  = baseErr | errEvt;
      mDrdy = (mDrdy & ~rdStatus) | (cfgDrdyEn & drdyEvent(cfgAutoscan, cfgSeqLen, convDone));
      mUnrd = (mUnrd & ~rdData & ~{4{rdStatus}}) | convDone;
      mIntN = !(!cfgIntDis && ((mErr & cfgErrMask) != 0 || (mDrdy && cfgDrdyEn)));
    end
  endtask

  task automatic compareAll();
    chk("R3 statErr", 32'(statErr), 32'(mErr));
    chk("R3 statErrChan", 32'(statErrChan), 32'(mChan));
    chk("R1 R2 statDrdy", 32'(statDrdy), 32'(mDrdy));
    chk("R4 unread", 32'(unread), 32'(mUnrd));
    chk("R6 intN", 32'(intN), 32'(mIntN));
  endtask

  task automatic idle();
    convDone = '0; errEvt = '0; rdStatus = 0; rdData = '0;
    sleepEnter = 0; swReset = 0; shutdown = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    compareAll();
    idle();
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    // R8 reset state
    chk("R8 statErr", 32'(statErr), 0);
    chk("R8 statDrdy", 32'(statDrdy), 0);
    chk("R8 unread", 32'(unread), 0);
    chk("R8 intN", 32'(intN), 1);
    rstN = 1'b1;
    cfgErrMask = 6'h3f; cfgDrdyEn = 1;

    // R1 single-channel mode: any conversion raises data-ready
    convDone = 4'b0100; tick();
    chk("R1 drdy single", 32'(statDrdy), 1);
    chk("R6 pin low", 32'(intN), 0);
    rdStatus = 1; tick();
    chk("R5 drdy cleared", 32'(statDrdy), 0);
    chk("R6 pin released", 32'(intN), 1);

    // R2 scan length 0: channel 0 alone does nothing, channel 1 ends scan
    cfgAutoscan = 1; cfgSeqLen = 0;
    convDone = 4'b0001; tick();
    chk("R2 not last", 32'(statDrdy), 0);
    convDone = 4'b0010; tick();
    chk("R2 last ch1", 32'(statDrdy), 1);
    rdStatus = 1; tick();
    cfgSeqLen = 2; convDone = 4'b0100; tick();
    chk("R2 ch2 not last len2", 32'(statDrdy), 0);
    convDone = 4'b1000; tick();
    chk("R2 last ch3", 32'(statDrdy), 1);
    rdStatus = 1; tick();

    // R3 first channel kept, R5 read and event in same cycle
    errEvt = 6'b000100; errChan = 2'd2; tick();
    errEvt = 6'b100000; errChan = 2'd1; tick();
    chk("R3 chan first", 32'(statErrChan), 2);
    chk("R3 bits", 32'(statErr), 32'h24);
    rdStatus = 1; errEvt = 6'b000001; errChan = 2'd3; tick();
    chk("R5 set wins", 32'(statErr), 1);
    chk("R5 chan new", 32'(statErrChan), 3);

    // R4 data read clears only its channel
    convDone = 4'b1010; tick();
    rdData = 4'b0010; tick();
    chk("R4 per channel", 32'(unread), 32'b1000);

    // R6 mask and disable
    rdStatus = 1; tick();
    cfgErrMask = 6'b000010; errEvt = 6'b000001; tick();
    chk("R6 masked", 32'(intN), 1);
    cfgIntDis = 1; errEvt = 6'b000010; tick();
    chk("R6 disabled", 32'(intN), 1);
    cfgIntDis = 0; tick();
    chk("R6 enabled", 32'(intN), 0);

    // R7 shutdown overrides same-cycle events
    shutdown = 1; errEvt = 6'h3f; convDone = 4'hf; tick();
    chk("R7 errs", 32'(statErr), 0);
    chk("R7 unread", 32'(unread), 0);
    chk("R7 pin", 32'(intN), 1);

    // random run
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 199) == 0) begin
        cfgAutoscan = 1'($urandom); cfgSeqLen = 2'($urandom);
        cfgErrMask = 6'($urandom); cfgDrdyEn = 1'($urandom);
        cfgIntDis = ($urandom_range(0, 3) == 0);
      end
      convDone = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'd0;
      errEvt = ($urandom_range(0, 7) == 0) ? (6'd1 << $urandom_range(0, 5)) : 6'd0;
      errChan = 2'($urandom);
      rdStatus = ($urandom_range(0, 9) == 0);
      rdData = ($urandom_range(0, 4) == 0) ? 4'($urandom) : 4'd0;
      sleepEnter = ($urandom_range(0, 149) == 0);
      swReset = ($urandom_range(0, 149) == 0);
      shutdown = ($urandom_range(0, 149) == 0);
      tick();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule